// File: doc/BRIEF.md
# Parallel and Byte Result Readout

This block hands a host eight stored conversion results over a parallel bus. Each result is 14 bits wide and goes out as a 16-bit word, left-aligned, with the two lowest bits at zero. The host reads with an active-low chip select and an active-low read strobe. In word mode every strobe yields one whole word on a 16-bit bus. In byte mode every strobe yields half a word on the low eight bus lines, and a pin picks which half comes first.

Chip select, read strobe and the two mode pins arrive asynchronously. Each passes through a two-flop synchronizer in the system clock domain. Edges are found on the synchronized copies. A chip-select falling edge opens a frame and captures both mode pins for that frame. Each read-strobe falling edge inside the frame steps to the next slot. The block drives a data-enable output so the bus can be tri-stated outside the chip. It also drives a first-channel flag with its own enable. The flag tells the host that channel 1 is on the bus.

Top module: `par_readout`

## Requirements
- R1: data_oe_o is high only while both synchronized cs_ni and rd_ni are low, and data_o reads all zero whenever data_oe_o is low, including when rd_ni falls while cs_ni is high.
- R2: After a rise of cs_ni, data_oe_o and first_oe_o both go low, which releases the bus and the flag.
- R3: Within a frame, the first rd_ni falling edge presents channel index 0 (channel 1), and each later word-mode falling edge presents the next index in ascending order.
- R4: In word mode, data_o equals the 14-bit result of the presented channel in bits 15:2, with bits 1:0 at zero.
- R5: In word mode, first_o is high after the first rd_ni fall of a frame, goes low on the second, and stays low for the rest of the frame.
- R6: In byte mode (byte_mode_i = 1), each channel takes two strobes, so a frame is 16 strobes long. The byte appears on data_o[7:0] and data_o[15:8] is zero.
- R7: In byte mode, hi_first_i = 1 sends bits 15:8 of the word on the first strobe of a channel and bits 7:0 on the second. hi_first_i = 0 reverses the order.
- R8: In byte mode, first_o is high for the first two strobes of a frame and low from the third strobe on.
- R9: Every cs_ni falling edge resets the pointer to channel 1 and re-arms the flag, even when the previous frame ended early.
- R10: Strobes past the last slot of a frame (the 9th in word mode, the 17th in byte mode) wrap back to channel 1 and leave first_o low.
- R11: byte_mode_i and hi_first_i are captured at the cs_ni falling edge. Changing them during a frame has no effect on the frame in progress.
- R12: After a cs_ni fall and before the first rd_ni fall, first_oe_o is high and first_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| byte_mode_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| hi_first_i | input | 1 | Byte order in byte mode: 1 sends the high byte first |
| result_i | input | 112 | Eight 14-bit results; channel n sits at bits [14n+13:14n] |
| data_o | output | 16 | Read data; zero when not enabled |
| data_oe_o | output | 1 | Enable for the data bus |
| first_o | output | 1 | First-channel flag |
| first_oe_o | output | 1 | Enable for the flag |

## Verification
The bench runs frames that stop before the last slot, and frames that run past it. A pointer that does not reset on chip select would start the next frame at the wrong channel. A missing wrap would read past channel 8, or would raise the flag again on the second pass. In byte mode, the bench flips both mode pins in the middle of a frame and checks both byte orders. A design that samples the pins live, or swaps the halves, would put the wrong byte on the bus. The bench also checks the flag on exactly the strobe where it must drop: the second strobe in word mode and the third in byte mode. It also pulses rd_ni with cs_ni high and checks that the bus stays disabled.

// File: rtl/readout_pkg.sv
package readout_pkg;
  typedef enum logic {MODE_WORD = 1'b0, MODE_BYTE = 1'b1} rd_mode_e;

  // phase 0 is the first strobe of a channel
  function automatic logic take_high(input logic phase, input logic hi_first);
    return (phase == 1'b0) ? hi_first : ~hi_first;
  endfunction
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rd_sequencer.sv
module rd_sequencer
  import readout_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_s_i,
  input  logic            rd_s_i,
  input  logic            byte_mode_s_i,
  input  logic            hi_first_s_i,
  output logic [CH_W-1:0] ch_o,
  output logic            phase_o,
  output rd_mode_e        mode_o,
  output logic            hi_first_o,
  output logic            data_oe_o,
  output logic            first_o,
  output logic            first_oe_o
);
  localparam int SLOTS = 2 * NCH;
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(NCH - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(SLOTS - 1);

  logic cs_prev_q, rd_prev_q;
  logic cs_fall, cs_rise, rd_fall;
  logic [CNT_W-1:0] next_q, cur_q, last_slot;
  logic first_pass_q, first_q, data_oe_q, first_oe_q, hi_first_q;
  rd_mode_e mode_q;
  logic [CH_W-1:0] next_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_s_i;
      rd_prev_q <= rd_s_i;
    end
  end

  assign cs_fall   = cs_prev_q & ~cs_s_i;
  assign cs_rise   = ~cs_prev_q & cs_s_i;
  assign rd_fall   = rd_prev_q & ~rd_s_i & ~cs_s_i & ~cs_fall;
  assign last_slot = (mode_q == MODE_BYTE) ? LAST_BYTE : LAST_WORD;
  assign next_ch   = (mode_q == MODE_BYTE) ? CH_W'(next_q >> 1) : CH_W'(next_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q       <= '0;
      cur_q        <= '0;
      first_pass_q <= 1'b1;
      first_q      <= 1'b0;
      mode_q       <= MODE_WORD;
      hi_first_q   <= 1'b0;
    end else if (cs_fall) begin
      next_q       <= '0;
      first_pass_q <= 1'b1;
      first_q      <= 1'b0;
      mode_q       <= rd_mode_e'(byte_mode_s_i);
      hi_first_q   <= hi_first_s_i;
    end else if (rd_fall) begin
      cur_q   <= next_q;
      first_q <= first_pass_q && (next_ch == '0);
      if (next_q == last_slot) begin
        next_q       <= '0;
        first_pass_q <= 1'b0;
      end else begin
        next_q <= next_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_oe_q  <= 1'b0;
      first_oe_q <= 1'b0;
    end else begin
      data_oe_q  <= ~cs_s_i & ~rd_s_i & ~cs_fall;
      first_oe_q <= ~cs_s_i;
    end
  end

  assign ch_o       = (mode_q == MODE_BYTE) ? CH_W'(cur_q >> 1) : CH_W'(cur_q);
  assign phase_o    = (mode_q == MODE_BYTE) ? cur_q[0] : 1'b0;
  assign mode_o     = mode_q;
  assign hi_first_o = hi_first_q;
  assign data_oe_o  = data_oe_q;
  assign first_o    = first_q;
  assign first_oe_o = first_oe_q;

  assert_bus_implies_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_q |-> first_oe_q);
  assert_release_on_cs_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (!data_oe_q && !first_oe_q));
  assert_no_flag_on_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && !first_pass_q) |=> !first_q);
  assert_flag_low_at_open_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !first_q);
  assert_slot_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_q <= last_slot);
  assert_mode_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> $stable(mode_q) && $stable(hi_first_q));
endmodule

// File: rtl/word_mux.sv
module word_mux
  import readout_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int RES_W  = 14,
  parameter int WORD_W = 16,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic [NCH*RES_W-1:0] result_i,
  input  logic [CH_W-1:0]      ch_i,
  input  logic                 phase_i,
  input  rd_mode_e             mode_i,
  input  logic                 hi_first_i,
  input  logic                 oe_i,
  output logic [WORD_W-1:0]    data_o
);
  localparam int PAD_W  = WORD_W - RES_W;
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] words [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_word
    assign words[g] = {result_i[g*RES_W +: RES_W], {PAD_W{1'b0}}};
  end

  logic [WORD_W-1:0] sel_word;
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_word = words[ch_i];
    sel_byte = take_high(phase_i, hi_first_i) ? sel_word[WORD_W-1 -: BYTE_W]
                                              : sel_word[BYTE_W-1:0];
    if (!oe_i)                  data_o = '0;
    else if (mode_i == MODE_BYTE) data_o = {{(WORD_W-BYTE_W){1'b0}}, sel_byte};
    else                        data_o = sel_word;
  end

  assert_pad_zero_R4: assert property (@(data_o) (oe_i && mode_i == MODE_WORD) |-> data_o[PAD_W-1:0] == '0);
endmodule

// File: rtl/par_readout.sv
module par_readout
  import readout_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int RES_W  = 14,
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 rd_ni,
  input  logic                 byte_mode_i,
  input  logic                 hi_first_i,
  input  logic [NCH*RES_W-1:0] result_i,
  output logic [WORD_W-1:0]    data_o,
  output logic                 data_oe_o,
  output logic                 first_o,
  output logic                 first_oe_o
);
  localparam int CH_W = $clog2(NCH);

  logic [3:0] raw, synced;
  logic [CH_W-1:0] ch;
  logic phase, hi_first;
  rd_mode_e mode;

  assign raw = {cs_ni, rd_ni, byte_mode_i, hi_first_i};

  rd_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  rd_sequencer #(.NCH(NCH)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(synced[3]), .rd_s_i(synced[2]),
    .byte_mode_s_i(synced[1]), .hi_first_s_i(synced[0]),
    .ch_o(ch), .phase_o(phase), .mode_o(mode), .hi_first_o(hi_first),
    .data_oe_o(data_oe_o), .first_o(first_o), .first_oe_o(first_oe_o)
  );

  word_mux #(.NCH(NCH), .RES_W(RES_W), .WORD_W(WORD_W)) u_mux (
    .result_i(result_i), .ch_i(ch), .phase_i(phase), .mode_i(mode),
    .hi_first_i(hi_first), .oe_i(data_oe_o), .data_o(data_o)
  );
endmodule

// File: tb/par_readout_tb.sv
module par_readout_tb;
  localparam int NCH = 8, RES_W = 14, WORD_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, byte_mode_i = 1'b0, hi_first_i = 1'b0;
  logic [NCH*RES_W-1:0] result_i = '0;
  logic [WORD_W-1:0] data_o;
  logic data_oe_o, first_o, first_oe_o;
  int total = 0, bad = 0;
  logic [RES_W-1:0] res [NCH];

  always #2.5 clk = ~clk;

  par_readout #(.NCH(NCH), .RES_W(RES_W), .WORD_W(WORD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .byte_mode_i(byte_mode_i), .hi_first_i(hi_first_i), .result_i(result_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .first_o(first_o), .first_oe_o(first_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_data(input logic bm, input logic hf, input int k);
    logic [15:0] w;
    int idx, ch;
    idx = bm ? (k % 16) : (k % 8);
    ch  = bm ? idx / 2 : idx;
    w   = {res[ch], 2'b00};
    if (!bm) return w;
    return (((idx % 2) == 0) == hf) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic logic exp_flag(input logic bm, input int k);
    return bm ? (k < 2) : (k == 0);
  endfunction

  task automatic load_results();
    for (int c = 0; c < NCH; c++) begin
      res[c] = RES_W'($urandom);
      result_i[c*RES_W +: RES_W] = res[c];
    end
  endtask

  // n strobes; flip pins after open to exercise R11
  task automatic frame(input logic bm, input logic hf, input int n, input logic flip);
    string rq;
    load_results();
    byte_mode_i = bm; hi_first_i = hf;
    settle();
    cs_ni = 1'b0;
    settle();
    chk("R12 flag enable at open", first_oe_o, 1);
    chk("R12 flag low at open", first_o, 0);
    chk("R1 bus off with rd high", data_oe_o, 0);
    if (flip) begin
      byte_mode_i = ~bm; hi_first_i = ~hf;
      settle();
    end
    for (int k = 0; k < n; k++) begin
      rd_ni = 1'b0;
      settle();
      rq = bm ? ((k >= 16) ? "R10 byte wrap" : (flip ? "R11 R7 byte" : "R6 R7 byte"))
              : ((k >= 8) ? "R10 word wrap" : "R3 R4 word");
      chk(rq, data_o, exp_data(bm, hf, k));
      chk("R1 bus enabled", data_oe_o, 1);
      chk(bm ? "R8 byte flag" : "R5 word flag", first_o, exp_flag(bm, k));
      rd_ni = 1'b1;
      settle();
      chk("R1 bus off between strobes", {data_oe_o, data_o}, 0);
    end
    cs_ni = 1'b1;
    settle();
    chk("R2 release", {data_oe_o, first_oe_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int c = 0; c < NCH; c++) res[c] = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset state", {data_oe_o, first_oe_o, first_o, data_o}, 0);
    rst_ni = 1'b1;
    settle();
    // rd strobe without chip select
    rd_ni = 1'b0; settle();
    chk("R1 rd without cs", {data_oe_o, data_o}, 0);
    rd_ni = 1'b1; settle();
    frame(1'b0, 1'b0, 8, 1'b0);
    frame(1'b0, 1'b1, 10, 1'b0);   // R10 word wrap
    frame(1'b0, 1'b0, 3, 1'b0);    // R9 early end
    frame(1'b0, 1'b0, 2, 1'b0);    // R9 restart at channel 1
    frame(1'b1, 1'b1, 16, 1'b0);
    frame(1'b1, 1'b0, 16, 1'b0);
    frame(1'b1, 1'b1, 18, 1'b0);   // R10 byte wrap
    frame(1'b1, 1'b0, 5, 1'b1);    // R11 pins flipped mid frame
    frame(1'b0, 1'b1, 4, 1'b1);    // R11 word kept
    for (int i = 0; i < 12; i++)
      frame(1'($urandom), 1'($urandom), 1 + int'($urandom % 20), 1'($urandom));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule